// File: doc/BRIEF.md
# Link Status Interrupt Aggregator

This block gathers status events from a display-link transmitter and turns them into one interrupt line. Two slow level inputs, hot-plug and receiver-sense, are brought into the clock domain through synchronizers. A change in either direction on either level latches its own source bit. A single-cycle bi-phase error pulse and a single-cycle dropped-sample pulse from the S/PDIF front end each latch a source bit. A dropped sample means a preamble came in before the current subframe was complete. A frame counter advances on each VSYNC pulse. When it reaches a programmable compare value it latches a source bit and restarts from zero. Firmware can also raise a source bit directly with a register write, without any hardware event.

Every latched source stays set until firmware clears it by writing 1 to its bit position. An unmask register decides which sources may take part. The unmasked sources are ORed into a summary state bit. The summary bit drives the interrupt pin, and a polarity control bit decides whether the pin is active high or active low. The registers are reached through a small single-cycle write port and a combinational read port.

Top module: `link_irq_aggregator`

## Requirements
- R1: After reset, the source register (address 0), the unmask register (address 1) and the control register (address 2) all read 0, the compare register (address 3) reads 128, and `irq_o` is low.
- R2: A change of `hpd_lvl_i`, rising or falling, sets source bit 0 at most three clock edges after the change.
- R3: A change of `rsense_lvl_i`, rising or falling, sets source bit 1 at most three clock edges after the change.
- R4: A one-cycle pulse on `biphase_err_i` sets source bit 2, and a one-cycle pulse on `drop_smp_i` sets source bit 3, at the next clock edge.
- R5: The frame counter counts `vsync_i` pulses. The pulse that brings the count to the compare value sets source bit 4 and returns the count to zero. With a compare value of N, the bit therefore sets on every Nth pulse, including N = 128.
- R6: Writing address 2 with bit 1 set sets source bit 5. Control bit 1 always reads back as 0.
- R7: Writing address 0 clears each source bit whose data bit is 1 and leaves the other source bits unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R8: The summary bit, read at address 2 bit 7, equals the OR over all source bits ANDed with their unmask bits at address 1 (bits 5:0). It updates one clock edge after the source or unmask bits change.
- R9: When polarity (address 2 bit 0) is 0, `irq_o` equals the summary bit. When polarity is 1, `irq_o` is the inverse of the summary bit.
- R10: The unmask register (bits 5:0 at address 1) and the compare register (8 bits at address 3) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpd_lvl_i | input | 1 | Hot-plug level, asynchronous |
| rsense_lvl_i | input | 1 | Receiver-sense level, asynchronous |
| biphase_err_i | input | 1 | Bi-phase error event pulse |
| drop_smp_i | input | 1 | Dropped-sample event pulse |
| vsync_i | input | 1 | One pulse per video frame |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| irq_o | output | 1 | Interrupt output, polarity programmable |

## Verification
The assertions assume that the event and VSYNC inputs are synchronous to `clk` and last exactly one cycle, and that the level inputs hold steady long enough to pass through the synchronizer. The bench drives every input at the falling edge. It holds each pulse for one cycle and waits several cycles after every level change before it reads the source register. The race between a clear and a new event is created on purpose, by driving the clearing write and the event pulse in the same cycle.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_SRC = 6;

    // source bit positions
    localparam int SRC_HPD   = 0;
    localparam int SRC_RSNS  = 1;
    localparam int SRC_BIPH  = 2;
    localparam int SRC_DROP  = 3;
    localparam int SRC_FRAME = 4;
    localparam int SRC_SOFT  = 5;

    // control register bit positions
    localparam int CTL_POL  = 0;
    localparam int CTL_SOFT = 1;
    localparam int CTL_SUM  = 7;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_SRC  = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_FCMP = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/lirq_edge_sync.sv
module lirq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic chg_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], lvl_i};
        st_d.prev = st_q.sh[STAGES-1];
        chg_o     = st_q.sh[STAGES-1] ^ st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2 R3: a reported change means the synchronized level moves on.
    assert_change_settles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |=> (st_q.prev == $past(st_q.sh[STAGES-1])));
endmodule

// File: rtl/lirq_frame_match.sv
module lirq_frame_match #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             match_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } frm_st_t;

    frm_st_t          st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + 1'b1;
        match_o = vsync_i && (cnt_inc == cmp_i);
        if (vsync_i) st_d.cnt = match_o ? '0 : cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a match restarts the frame count from zero
    assert_match_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> (st_q.cnt == '0));

    // R5: without a frame pulse the count holds
    assert_count_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_i |=> $stable(st_q.cnt));
endmodule

// File: rtl/lirq_src_bank.sv
module lirq_src_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] src_o
);
    typedef struct packed {
        logic [N-1:0] src;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set has priority over a clear in the same cycle
        for (int i = 0; i < N; i++) begin
            if (set_i[i])      st_d.src[i] = 1'b1;
            else if (clr_i[i]) st_d.src[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_o = st_q.src;

    // R7: a source bit only drops when it was cleared
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(st_q.src) & ~$past(clr_i)) & ~st_q.src) == '0));

    // R4: every event latches its bit at the next edge
    assert_event_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_i) & ~st_q.src) == '0));
endmodule

// File: rtl/link_irq_aggregator.sv
module link_irq_aggregator
    import lirq_pkg::*;
#(
    parameter int               SYNC_STAGES  = 2,
    parameter int               CNT_W        = 8,
    parameter logic [CNT_W-1:0] FRM_CMP_RST  = 8'd128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hpd_lvl_i,
    input  logic              rsense_lvl_i,
    input  logic              biphase_err_i,
    input  logic              drop_smp_i,
    input  logic              vsync_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam int NUM_LVL = 2;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic               pol;
        logic [CNT_W-1:0]   cmp;
        logic               summary;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic [NUM_LVL-1:0] lvl_in, lvl_chg;
    logic               frame_hit;
    logic [NUM_SRC-1:0] src_set, src_clr, src;
    logic               wr_src, wr_mask, wr_ctrl, wr_fcmp;

    assign lvl_in = {rsense_lvl_i, hpd_lvl_i};

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        lirq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_i (lvl_in[g]),
            .chg_o (lvl_chg[g])
        );
    end

    lirq_frame_match #(.CNT_W(CNT_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync_i (vsync_i),
        .cmp_i   (st_q.cmp),
        .match_o (frame_hit)
    );

    always_comb begin
        wr_src  = reg_wr_i && (reg_addr_i == ADDR_SRC);
        wr_mask = reg_wr_i && (reg_addr_i == ADDR_MASK);
        wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
        wr_fcmp = reg_wr_i && (reg_addr_i == ADDR_FCMP);

        src_set            = '0;
        src_set[SRC_HPD]   = lvl_chg[0];
        src_set[SRC_RSNS]  = lvl_chg[1];
        src_set[SRC_BIPH]  = biphase_err_i;
        src_set[SRC_DROP]  = drop_smp_i;
        src_set[SRC_FRAME] = frame_hit;
        src_set[SRC_SOFT]  = wr_ctrl && reg_wdata_i[CTL_SOFT];

        src_clr = wr_src ? reg_wdata_i[NUM_SRC-1:0] : '0;
    end

    lirq_src_bank #(.N(NUM_SRC)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (src_set),
        .clr_i (src_clr),
        .src_o (src)
    );

    always_comb begin
        st_d         = st_q;
        st_d.summary = |(src & st_q.mask);
        if (wr_mask) st_d.mask = reg_wdata_i[NUM_SRC-1:0];
        if (wr_ctrl) st_d.pol  = reg_wdata_i[CTL_POL];
        if (wr_fcmp) st_d.cmp  = reg_wdata_i[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cmp <= FRM_CMP_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_SRC:  reg_rdata_o[NUM_SRC-1:0] = src;
            ADDR_MASK: reg_rdata_o[NUM_SRC-1:0] = st_q.mask;
            ADDR_CTRL: begin
                reg_rdata_o[CTL_POL] = st_q.pol;
                reg_rdata_o[CTL_SUM] = st_q.summary;
            end
            default:   reg_rdata_o[CNT_W-1:0] = st_q.cmp;
        endcase
    end

    assign irq_o = st_q.summary ^ st_q.pol;

    // R8: with every source masked the summary falls at the next edge
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |=> !st_q.summary);

    // R8: summary can only rise when some unmasked source was pending
    assert_summary_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.summary) |-> ($past(src & st_q.mask) != '0));

    // R9: a steady summary and polarity keep the pin steady
    assert_pin_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(st_q.summary) && $stable(st_q.pol)) |-> $stable(irq_o));
endmodule

// File: tb/link_irq_aggregator_test.sv
`timescale 1ns/1ps
module link_irq_aggregator_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       hpd = 0, rsns = 0, biph = 0, drop = 0, vs = 0;
    logic       wr = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       irq;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    link_irq_aggregator uut (
        .clk(clk), .rst_n(rst_n), .hpd_lvl_i(hpd), .rsense_lvl_i(rsns),
        .biphase_err_i(biph), .drop_smp_i(drop), .vsync_i(vs),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0; wdata = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic vsync_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); vs = 1;
            @(negedge clk); vs = 0;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd_reg(0, d); chk(d, 8'h00, "R1 source reset");
        rd_reg(1, d); chk(d, 8'h00, "R1 unmask reset");
        rd_reg(2, d); chk(d, 8'h00, "R1 control reset");
        rd_reg(3, d); chk(d, 8'd128, "R1 compare reset");
        chk({7'd0, irq}, 8'h00, "R1 irq reset");
    endtask

    task automatic t_hotplug;
        logic [7:0] d;
        @(negedge clk); hpd = 1; wait_cyc(4);
        rd_reg(0, d); chk(d, 8'h01, "R2 hotplug rise");
        wr_reg(0, 8'h01);
        rd_reg(0, d); chk(d, 8'h00, "R2 hotplug cleared");
        @(negedge clk); hpd = 0; wait_cyc(4);
        rd_reg(0, d); chk(d, 8'h01, "R2 hotplug fall");
        wr_reg(0, 8'h01);
    endtask

    task automatic t_rsense;
        logic [7:0] d;
        @(negedge clk); rsns = 1; wait_cyc(4);
        rd_reg(0, d); chk(d, 8'h02, "R3 rsense rise");
        wr_reg(0, 8'h02);
        @(negedge clk); rsns = 0; wait_cyc(4);
        rd_reg(0, d); chk(d, 8'h02, "R3 rsense fall");
        wr_reg(0, 8'h02);
    endtask

    task automatic t_spdif;
        logic [7:0] d;
        @(negedge clk); biph = 1; @(negedge clk); biph = 0;
        rd_reg(0, d); chk(d, 8'h04, "R4 biphase");
        @(negedge clk); drop = 1; @(negedge clk); drop = 0;
        rd_reg(0, d); chk(d, 8'h0C, "R4 dropped sample");
        wr_reg(0, 8'h04);
        rd_reg(0, d); chk(d, 8'h08, "R7 selective clear");
        wr_reg(0, 8'h00);
        rd_reg(0, d); chk(d, 8'h08, "R7 zero write keeps");
        wr_reg(0, 8'h3F);
        rd_reg(0, d); chk(d, 8'h00, "R7 clear all");
    endtask

    task automatic t_clear_race;
        logic [7:0] d;
        @(negedge clk); wr = 1; addr = 0; wdata = 8'h04; biph = 1;
        @(negedge clk); wr = 0; wdata = 0; biph = 0;
        rd_reg(0, d); chk(d, 8'h04, "R7 event beats clear");
        wr_reg(0, 8'h04);
    endtask

    task automatic t_frame;
        logic [7:0] d;
        wr_reg(3, 8'd3);
        rd_reg(3, d); chk(d, 8'd3, "R10 compare readback");
        vsync_pulses(2);
        rd_reg(0, d); chk(d, 8'h00, "R5 below compare");
        vsync_pulses(1);
        rd_reg(0, d); chk(d, 8'h10, "R5 compare hit");
        wr_reg(0, 8'h10);
        vsync_pulses(2);
        rd_reg(0, d); chk(d, 8'h00, "R5 restart below");
        vsync_pulses(1);
        rd_reg(0, d); chk(d, 8'h10, "R5 second hit");
        wr_reg(0, 8'h10);
        wr_reg(3, 8'd128);
        vsync_pulses(127);
        rd_reg(0, d); chk(d, 8'h00, "R5 127 frames");
        vsync_pulses(1);
        rd_reg(0, d); chk(d, 8'h10, "R5 128 frames");
        wr_reg(0, 8'h10);
    endtask

    task automatic t_soft;
        logic [7:0] d;
        wr_reg(2, 8'h02);
        rd_reg(0, d); chk(d, 8'h20, "R6 soft source");
        rd_reg(2, d); chk(d, 8'h00, "R6 soft bit reads zero");
        chk({7'd0, irq}, 8'h00, "R8 masked no irq");
    endtask

    task automatic t_summary;
        logic [7:0] d;
        wr_reg(1, 8'h20);
        rd_reg(1, d); chk(d, 8'h20, "R10 unmask readback");
        rd_reg(2, d); chk(d, 8'h80, "R8 summary set");
        chk({7'd0, irq}, 8'h01, "R9 active high");
        wr_reg(2, 8'h01);
        rd_reg(2, d); chk(d, 8'h81, "R9 polarity readback");
        chk({7'd0, irq}, 8'h00, "R9 active low asserted");
        wr_reg(0, 8'h20);
        rd_reg(2, d); chk(d, 8'h01, "R8 summary cleared");
        chk({7'd0, irq}, 8'h01, "R9 active low idle");
        @(negedge clk); biph = 1; @(negedge clk); biph = 0;
        wait_cyc(1);
        rd_reg(2, d); chk(d, 8'h01, "R8 masked source ignored");
        wr_reg(1, 8'h24);
        rd_reg(2, d); chk(d, 8'h81, "R8 unmask pending source");
        wr_reg(2, 8'h00);
        chk({7'd0, irq}, 8'h01, "R9 back to active high");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);
        t_reset;
        t_hotplug;
        t_rsense;
        t_spdif;
        t_clear_race;
        t_frame;
        t_soft;
        t_summary;
        wait_cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule